// File: doc/BRIEF.md
# In-Order Dual-Issue Pairing Checker

This block decides, once per cycle, how many instructions an in-order core with two issue slots sends into execution. It sees the class codes of the two oldest decoded instructions, older first, each with a valid bit. It answers with three signals: issue the older one, also issue the younger one, or stall. Whether two instructions may go out together depends on the class of each and on its position in the pair. Some classes may only lead a pair, some may only trail one, and some never pair. A few classes keep the execution resources for more cycles after they issue. The block tracks that occupancy and holds off all issue until it ends.

The issue decision is combinational from the slot inputs and the registered occupancy state. Occupancy changes on the clock edge that follows an issue. When only the older instruction issues, the queue in front of the block shifts the younger instruction into the older position for the next cycle. This block keeps no copy of it. Dependency checks, forwarding, decoding and the execution units lie outside this block.

Top module: `dual_issue_pair`

## Requirements
- R1: The younger instruction issues only in a cycle in which the older instruction also issues.
- R2: A direct branch (class code 1) may lead or trail a pair. Two control-flow instructions (class codes 1 and 2) never issue in the same cycle.
- R3: A call (class code 2) never leads a pair. It may issue alone or as the younger instruction.
- R4: An immediate-operand ALU instruction (class code 3) may lead a pair or trail one, behind any class that is allowed to lead.
- R5: A register-operand ALU instruction (class code 4) leads a pair only when the younger instruction is class 3. It never trails.
- R6: A single load or store (class code 7) may lead a pair behind which a class 1, 2 or 3 instruction trails. Only classes 1, 2 and 3 ever trail.
- R7: Multiply (class code 5) and double-word load or store (class code 8) never pair. They leave no stall after the cycle in which they issue.
- R8: An integer divide (class code 6) never pairs. It holds both slots for DIV_CYCLES consecutive cycles: stall is high and nothing issues in the DIV_CYCLES-1 cycles after it issues.
- R9: A four-register transfer (class code 10) holds both slots for WIDE_CYCLES cycles, and a generic vector operation (class code 11) holds them for VEC_CYCLES cycles. Neither pairs, and in the cycles after issue the block stalls as in R8.
- R10: A three-register transfer (class code 9) never pairs. In the next cycle stall stays low, the older instruction may issue, and the younger one may not.
- R11: Code 0 is a bubble and codes 12 to 31 are undefined. A slot that is invalid or carries one of these codes never issues. If the older slot cannot issue, nothing issues.
- R12: After reset, stall is low and no occupancy is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| older_vld | input | 1 | Older slot holds an instruction |
| older_cls | input | 5 | Class code of the older instruction |
| younger_vld | input | 1 | Younger slot holds an instruction |
| younger_cls | input | 5 | Class code of the younger instruction |
| issue_older | output | 1 | Older instruction issues this cycle |
| issue_younger | output | 1 | Younger instruction issues alongside it |
| stall | output | 1 | Multi-cycle occupancy blocks all issue |

## Verification
The bench builds the block with its default parameters: a divide occupancy of 5 cycles and both wide-hold lengths at 2. At these values every occupancy window stays short enough to walk through cycle by cycle. It sweeps every pair of 5-bit class codes under all four combinations of the valid bits, starting each time from an idle state. After each issue it follows the stall window to its end with a pairable probe pair, so the length of every hold and the single-issue cycle after a three-register transfer are both measured at the ports.

// File: rtl/dual_issue_pkg.sv
package dual_issue_pkg;

    localparam int CLS_W = 5;

    typedef enum logic [CLS_W-1:0] {
        CLS_NONE    = 5'd0,
        CLS_BR      = 5'd1,
        CLS_CALL    = 5'd2,
        CLS_ALU_IMM = 5'd3,
        CLS_ALU_REG = 5'd4,
        CLS_MUL     = 5'd5,
        CLS_IDIV    = 5'd6,
        CLS_MEM1    = 5'd7,
        CLS_MEM2    = 5'd8,
        CLS_XFER3   = 5'd9,
        CLS_XFER4   = 5'd10,
        CLS_VEC     = 5'd11
    } ins_cls_e;

    // Pairing attributes of one decoded class
    typedef struct packed {
        logic known;      // a defined, issuable class
        logic flow;       // control flow (branch or call)
        logic lead_ok;    // may be the older half of a pair
        logic trail_ok;   // may be the younger half of a pair
        logic imm;        // immediate-based ALU operation
        logic need_imm;   // pairs only with an immediate-based younger
    } cls_attr_t;

endpackage

// File: rtl/dip_class_decode.sv
module dip_class_decode
    import dual_issue_pkg::*;
(
    input  logic [CLS_W-1:0] cls_i,
    output cls_attr_t        attr_o
);

    always_comb begin
        attr_o = '0;
        case (cls_i)
            CLS_BR: begin
                attr_o.known    = 1'b1;
                attr_o.flow     = 1'b1;
                attr_o.lead_ok  = 1'b1;
                attr_o.trail_ok = 1'b1;
            end
            CLS_CALL: begin
                attr_o.known    = 1'b1;
                attr_o.flow     = 1'b1;
                attr_o.trail_ok = 1'b1;
            end
            CLS_ALU_IMM: begin
                attr_o.known    = 1'b1;
                attr_o.lead_ok  = 1'b1;
                attr_o.trail_ok = 1'b1;
                attr_o.imm      = 1'b1;
            end
            CLS_ALU_REG: begin
                attr_o.known    = 1'b1;
                attr_o.lead_ok  = 1'b1;
                attr_o.need_imm = 1'b1;
            end
            CLS_MEM1: begin
                attr_o.known    = 1'b1;
                attr_o.lead_ok  = 1'b1;
            end
            CLS_MUL, CLS_IDIV, CLS_MEM2, CLS_XFER3, CLS_XFER4, CLS_VEC: begin
                attr_o.known    = 1'b1;
            end
            default: attr_o = '0;
        endcase
    end

endmodule

// File: rtl/dip_pair_rule.sv
module dip_pair_rule
    import dual_issue_pkg::*;
(
    input  logic      old_vld_i,
    input  cls_attr_t old_attr_i,
    input  logic      yng_vld_i,
    input  cls_attr_t yng_attr_i,
    input  logic      full_busy_i,
    input  logic      half_hold_i,
    output logic      issue_old_o,
    output logic      issue_yng_o
);

    logic pos_ok;
    logic flow_clash;
    logic imm_ok;

    always_comb begin
        pos_ok      = old_attr_i.lead_ok && yng_attr_i.trail_ok;
        flow_clash  = old_attr_i.flow && yng_attr_i.flow;
        imm_ok      = !old_attr_i.need_imm || yng_attr_i.imm;
        issue_old_o = old_vld_i && old_attr_i.known && !full_busy_i;
        issue_yng_o = issue_old_o && yng_vld_i && yng_attr_i.known
                      && pos_ok && !flow_clash && imm_ok && !half_hold_i;
    end

endmodule

// File: rtl/dip_occupancy.sv
module dip_occupancy
    import dual_issue_pkg::*;
#(
    parameter int DIV_CYCLES  = 5,
    parameter int VEC_CYCLES  = 2,
    parameter int WIDE_CYCLES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch_i,
    input  logic [CLS_W-1:0] cls_i,
    output logic             full_busy_o,
    output logic             half_hold_o
);

    localparam int LONG_A  = (DIV_CYCLES > VEC_CYCLES) ? DIV_CYCLES : VEC_CYCLES;
    localparam int LONGEST = (LONG_A > WIDE_CYCLES) ? LONG_A : WIDE_CYCLES;
    localparam int CNT_W   = $clog2(LONGEST + 1);

    localparam logic [CNT_W-1:0] DIV_EXTRA  = CNT_W'(DIV_CYCLES - 1);
    localparam logic [CNT_W-1:0] VEC_EXTRA  = CNT_W'(VEC_CYCLES - 1);
    localparam logic [CNT_W-1:0] WIDE_EXTRA = CNT_W'(WIDE_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] full_cnt;
        logic             half;
    } occ_t;

    occ_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (st_q.full_cnt != '0) begin
            st_d.full_cnt = st_q.full_cnt - 1'b1;
            st_d.half     = 1'b0;
        end else begin
            st_d.half     = launch_i && (cls_i == CLS_XFER3);
            st_d.full_cnt = '0;
            if (launch_i) begin
                case (cls_i)
                    CLS_IDIV:  st_d.full_cnt = DIV_EXTRA;
                    CLS_VEC:   st_d.full_cnt = VEC_EXTRA;
                    CLS_XFER4: st_d.full_cnt = WIDE_EXTRA;
                    default:   st_d.full_cnt = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full_busy_o = (st_q.full_cnt != '0);
    assign half_hold_o = st_q.half;

    AST_LAUNCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        launch_i |-> !full_busy_o);                                        // R8
    AST_HALF_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        half_hold_o |-> !full_busy_o);                                     // R10

endmodule

// File: rtl/dual_issue_pair.sv
module dual_issue_pair
    import dual_issue_pkg::*;
#(
    parameter int DIV_CYCLES  = 5,
    parameter int VEC_CYCLES  = 2,
    parameter int WIDE_CYCLES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       older_vld,
    input  logic [4:0] older_cls,
    input  logic       younger_vld,
    input  logic [4:0] younger_cls,
    output logic       issue_older,
    output logic       issue_younger,
    output logic       stall
);

    localparam int SLOTS = 2;

    logic [SLOTS-1:0][CLS_W-1:0] slot_cls;
    cls_attr_t                   slot_attr [SLOTS];
    logic                        full_busy;
    logic                        half_hold;

    assign slot_cls[0] = older_cls;
    assign slot_cls[1] = younger_cls;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        dip_class_decode u_dec (
            .cls_i  (slot_cls[g]),
            .attr_o (slot_attr[g])
        );
    end

    dip_pair_rule u_rule (
        .old_vld_i   (older_vld),
        .old_attr_i  (slot_attr[0]),
        .yng_vld_i   (younger_vld),
        .yng_attr_i  (slot_attr[1]),
        .full_busy_i (full_busy),
        .half_hold_i (half_hold),
        .issue_old_o (issue_older),
        .issue_yng_o (issue_younger)
    );

    dip_occupancy #(
        .DIV_CYCLES  (DIV_CYCLES),
        .VEC_CYCLES  (VEC_CYCLES),
        .WIDE_CYCLES (WIDE_CYCLES)
    ) u_occ (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch_i    (issue_older),
        .cls_i       (older_cls),
        .full_busy_o (full_busy),
        .half_hold_o (half_hold)
    );

    assign stall = full_busy;

    AST_YNG_WITH_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        issue_younger |-> issue_older);                                    // R1
    AST_ONE_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
        issue_younger |-> !((older_cls == CLS_BR || older_cls == CLS_CALL)
                         && (younger_cls == CLS_BR || younger_cls == CLS_CALL))); // R2
    AST_CALL_NOT_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        issue_younger |-> older_cls != CLS_CALL);                          // R3
    AST_REG_NEEDS_IMM: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_younger && older_cls == CLS_ALU_REG) |-> younger_cls == CLS_ALU_IMM); // R5
    AST_TRAIL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        issue_younger |-> (younger_cls == CLS_BR || younger_cls == CLS_CALL
                        || younger_cls == CLS_ALU_IMM));                   // R6
    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !issue_older);                                           // R8
    AST_DIV_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (DIV_CYCLES > 1 && issue_older && older_cls == CLS_IDIV) |=> stall); // R8
    AST_WIDE_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (WIDE_CYCLES > 1 && issue_older && older_cls == CLS_XFER4) |=> stall); // R9
    AST_XFER3_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_older && older_cls == CLS_XFER3) |=> (!stall && !issue_younger)); // R10
    AST_UNDEF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (older_cls > CLS_VEC || older_cls == CLS_NONE) |-> !issue_older);  // R11

endmodule

// File: tb/dual_issue_pair_tb.sv
module dual_issue_pair_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DIV_C  = 5;
    localparam int VEC_C  = 2;
    localparam int WIDE_C = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       older_vld = 1'b0;
    logic [4:0] older_cls = '0;
    logic       younger_vld = 1'b0;
    logic [4:0] younger_cls = '0;
    logic       issue_older;
    logic       issue_younger;
    logic       stall;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_issue_pair #(
        .DIV_CYCLES  (DIV_C),
        .VEC_CYCLES  (VEC_C),
        .WIDE_CYCLES (WIDE_C)
    ) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .older_vld     (older_vld),
        .older_cls     (older_cls),
        .younger_vld   (younger_vld),
        .younger_cls   (younger_cls),
        .issue_older   (issue_older),
        .issue_younger (issue_younger),
        .stall         (stall)
    );

    task automatic chk(input string req, input int act, input int exp, input int o, input int y);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s older=%0d younger=%0d actual=%0d expected=%0d", req, o, y, act, exp);
        end
    endtask

    // Expected behaviour derived from the requirement list
    function automatic bit defined_c(input int c);  return c >= 1 && c <= 11; endfunction
    function automatic bit flow_c(input int c);     return c == 1 || c == 2; endfunction
    function automatic bit lead_c(input int c);     return c == 1 || c == 3 || c == 4 || c == 7; endfunction
    function automatic bit trail_c(input int c);    return c == 1 || c == 2 || c == 3; endfunction
    function automatic int extra_c(input int c);
        if (c == 6) return DIV_C - 1;
        if (c == 10) return WIDE_C - 1;
        if (c == 11) return VEC_C - 1;
        return 0;
    endfunction

    task automatic drive(input bit ov, input int oc, input bit yv, input int yc);
        older_vld   = ov;
        older_cls   = 5'(oc);
        younger_vld = yv;
        younger_cls = 5'(yc);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R12 stall in reset", int'(stall), 0, 0, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R12 stall after reset", int'(stall), 0, 0, 0);

        for (int oc = 0; oc < 32; oc++) begin
            for (int yc = 0; yc < 32; yc++) begin
                for (int v = 0; v < 4; v++) begin
                    bit ov = v[0];
                    bit yv = v[1];
                    bit e_o;
                    bit e_y;
                    int e_x;
                    bit e_h;
                    e_o = ov && defined_c(oc);
                    e_y = e_o && yv && defined_c(yc) && lead_c(oc) && trail_c(yc)
                          && !(flow_c(oc) && flow_c(yc)) && (oc != 4 || yc == 3);
                    e_x = e_o ? extra_c(oc) : 0;
                    e_h = e_o && oc == 9;

                    @(negedge clk);
                    drive(ov, oc, yv, yc);
                    #1;
                    // R1..R7, R11: pairing decision from an idle state
                    chk("R11 older issue", int'(issue_older), int'(e_o), oc, yc);
                    chk("R1-pair younger issue", int'(issue_younger), int'(e_y), oc, yc);
                    chk("R7 no stall when idle", int'(stall), 0, oc, yc);

                    // R8, R9: stall window probed with a pairable pair
                    for (int k = 0; k < e_x; k++) begin
                        @(negedge clk);
                        drive(1'b1, 3, 1'b1, 3);
                        #1;
                        chk("R8 R9 stall held", int'(stall), 1, oc, yc);
                        chk("R8 R9 older blocked", int'(issue_older), 0, oc, yc);
                        chk("R8 R9 younger blocked", int'(issue_younger), 0, oc, yc);
                    end

                    // R10 and end of window: next probe issues
                    @(negedge clk);
                    drive(1'b1, 3, 1'b1, 3);
                    #1;
                    chk("R7 R8 stall released", int'(stall), 0, oc, yc);
                    chk("R4 older after window", int'(issue_older), 1, oc, yc);
                    chk("R10 single issue after xfer3", int'(issue_younger), int'(!e_h), oc, yc);
                end
            end
        end

        // R2, R3 spot checks: branch trailing a call is refused, call trailing a branch-free leader is taken
        @(negedge clk);
        drive(1'b1, 2, 1'b1, 1);
        #1;
        chk("R3 call never leads", int'(issue_younger), 0, 2, 1);
        @(negedge clk);
        drive(1'b1, 3, 1'b1, 2);
        #1;
        chk("R3 call trails immediate ALU", int'(issue_younger), 1, 3, 2);
        @(negedge clk);
        drive(1'b1, 1, 1'b1, 1);
        #1;
        chk("R2 two branches refused", int'(issue_younger), 0, 1, 1);

        @(negedge clk);
        drive(1'b0, 0, 1'b0, 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule